// File: doc/BRIEF.md
# Directed-Rounding Significand Incrementer

This stage takes an unpacked significand whose two lowest bits are a guard bit and a round bit. It also takes a separate sticky bit, the sign of the value and a 2-bit rounding-mode field. It removes the two extra low bits and decides whether one unit in the last place must be added. It then registers the rounded significand together with two flags: rounded-up, and inexact (some information was lost).

The increment ripples through the whole fraction. An all-ones fraction therefore carries into an extra integer bit at the top of the output, giving the value 2.0 in the caller's fixed-point view. This stage does not renormalise that value. The downstream packer sees the carry bit and adjusts the exponent. Exponent arithmetic, packing into storage formats and exception delivery belong to other blocks.

The stage has one register between input and output. A new operand is accepted on every cycle in which the input strobe is high.

Top module: `rnd_incr_top`

## Requirements
- R1: One clock edge after a cycle with `inValid` high, `sigOut` (width SIG_W-1) equals the input significand shifted right by two and zero-extended by one bit, plus 1 when `roundedUp` is 1.
- R2: When the guard bit (`sigIn[1]`), the round bit (`sigIn[0]`) and `stickyIn` are all zero, both `roundedUp` and `inexact` are 0 in every mode.
- R3: When any of guard, round or sticky is 1, `inexact` is 1 in every mode.
- R4: In mode 2'b00 (nearest), the stage rounds up only when guard is 1. With guard at 1, it rounds up if round or sticky is 1, or if the shifted LSB (`sigIn[2]`) is 1 (ties go to even).
- R5: In mode 2'b01 (toward zero), `roundedUp` is always 0.
- R6: In mode 2'b10 (toward +infinity), the stage rounds up on an inexact value only when `signIn` is 0. In mode 2'b11 (toward -infinity), it does so only when `signIn` is 1.
- R7: The increment carries through the full fraction. An all-ones shifted fraction that is rounded up sets the top output bit `sigOut[SIG_W-2]` and clears all lower bits.
- R8: `outValid` repeats `inValid` one edge later. While `inValid` is low, `sigOut`, `roundedUp` and `inexact` hold their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand strobe |
| sigIn | input | SIG_W | Significand; bit 1 is guard, bit 0 is round |
| stickyIn | input | 1 | OR of all bits below round |
| signIn | input | 1 | Sign of the value, 1 = negative |
| modeIn | input | 2 | Rounding mode: 00 nearest, 01 toward zero, 10 toward +inf, 11 toward -inf |
| outValid | output | 1 | Result strobe |
| sigOut | output | SIG_W-1 | Rounded significand; top bit is the carry into the integer position |
| roundedUp | output | 1 | One unit in the last place was added |
| inexact | output | 1 | Guard, round or sticky was nonzero |

## Verification
The increment decision and the carry out of the full fraction can both occur on the same operand. This happens when an all-ones fraction rounds up, which raises inexact, rounded-up and the integer carry bit together. The bench provokes this in nearest mode and in both directed modes with the sign chosen to round up. It also applies the same fraction with the opposite sign, and in toward-zero mode, to show that the carry then stays clear. A behavioural model predicts all three outputs for every operand, including a long pseudo-random run, and compares them one edge after each operand is applied.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_PINF = 2'b10,
    RM_NINF = 2'b11
  } rndMode_e;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic bump;  // add one unit in the last place
    logic lost;  // nonzero bits were discarded
  } rndStrobe_t;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic       guardBit,
  input  logic       roundBit,
  input  logic       stickyBit,
  input  logic       lsbBit,
  input  logic       signBit,
  input  logic [1:0] mode,
  output rndStrobe_t strobe
);
  logic anyLost;
  logic nearUp;

  assign anyLost = guardBit | roundBit | stickyBit;
  assign nearUp  = guardBit & (roundBit | stickyBit | lsbBit);

  always_comb begin
    strobe.lost = anyLost;
    strobe.bump = 1'b0;
    unique case (rndMode_e'(mode))
      RM_ZERO: strobe.bump = 1'b0;
      RM_PINF: strobe.bump = anyLost & ~signBit;
      RM_NINF: strobe.bump = anyLost & signBit;
      default: strobe.bump = nearUp;
    endcase
  end
endmodule

// File: rtl/rnd_datapath.sv
module rnd_datapath
  import rnd_pkg::*;
#(
  parameter int SIG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SIG_W-1:0] sigIn,
  input  rndStrobe_t       strobe,
  output logic             outValid,
  output logic [SIG_W-2:0] sigOut,
  output logic             roundedUp,
  output logic             inexact
);
  localparam int FRAC_W = SIG_W - 2;

  logic [FRAC_W-1:0] frac;
  logic [FRAC_W:0]   carry;
  logic [FRAC_W-1:0] fracSum;

  assign frac     = sigIn[SIG_W-1:2];
  assign carry[0] = strobe.bump;

  // half-adder ripple chain for the unit increment
  for (genvar i = 0; i < FRAC_W; i++) begin : g_inc
    assign fracSum[i]  = frac[i] ^ carry[i];
    assign carry[i+1]  = frac[i] & carry[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      sigOut    <= '0;
      roundedUp <= 1'b0;
      inexact   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        sigOut    <= {carry[FRAC_W], fracSum};
        roundedUp <= strobe.bump;
        inexact   <= strobe.lost;
      end
    end
  end
endmodule

// File: rtl/rnd_incr_top.sv
module rnd_incr_top
  import rnd_pkg::*;
#(
  parameter int SIG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [SIG_W-1:0] sigIn,
  input  logic             stickyIn,
  input  logic             signIn,
  input  logic [1:0]       modeIn,
  output logic             outValid,
  output logic [SIG_W-2:0] sigOut,
  output logic             roundedUp,
  output logic             inexact
);
  rndStrobe_t strobe;

  rnd_decide u_decide (
    .guardBit (sigIn[1]),
    .roundBit (sigIn[0]),
    .stickyBit(stickyIn),
    .lsbBit   (sigIn[2]),
    .signBit  (signIn),
    .mode     (modeIn),
    .strobe   (strobe)
  );

  rnd_datapath #(.SIG_W(SIG_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .sigIn    (sigIn),
    .strobe   (strobe),
    .outValid (outValid),
    .sigOut   (sigOut),
    .roundedUp(roundedUp),
    .inexact  (inexact)
  );

  AST_SUM_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> sigOut == ({1'b0, $past(sigIn[SIG_W-1:2])} + (SIG_W-1)'(roundedUp))); // R1
  AST_EXACT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && sigIn[1:0] == 2'b00 && !stickyIn) |=> (!inexact && !roundedUp)); // R2
  AST_UP_IS_INEXACT: assert property (@(posedge clk) disable iff (!rstN)
    roundedUp |-> inexact); // R3
  AST_RTZ_NO_BUMP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeIn == 2'b01) |=> !roundedUp); // R5
  AST_DIR_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeIn[1] && (signIn != modeIn[0])) |=> !roundedUp); // R6
  AST_CARRY_NEEDS_UP: assert property (@(posedge clk) disable iff (!rstN)
    sigOut[SIG_W-2] |-> roundedUp); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(sigOut) && $stable(inexact) && $stable(roundedUp))); // R8
endmodule

// File: tb/rnd_incr_top_tb.sv
module rnd_incr_top_tb;
  localparam int SIG_W = 32;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic [SIG_W-1:0] sigIn = '0;
  logic             stickyIn = 1'b0;
  logic             signIn = 1'b0;
  logic [1:0]       modeIn = 2'b00;
  logic             outValid;
  logic [SIG_W-2:0] sigOut;
  logic             roundedUp;
  logic             inexact;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  // model state: what the outputs should show at the next check
  logic             expValid = 1'b0;
  logic [SIG_W-2:0] expSig = '0;
  logic             expUp = 1'b0;
  logic             expInx = 1'b0;
  string            expTag = "R8";

  always #5 clk = ~clk;

  rnd_incr_top #(.SIG_W(SIG_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .sigIn(sigIn),
    .stickyIn(stickyIn), .signIn(signIn), .modeIn(modeIn),
    .outValid(outValid), .sigOut(sigOut), .roundedUp(roundedUp), .inexact(inexact)
  );

  task automatic compareNow();
    vecCount++;
    if (outValid !== expValid || sigOut !== expSig || roundedUp !== expUp || inexact !== expInx) begin
      failCount++;
      $display("FAIL %s: got valid=%0b sig=%h up=%0b inx=%0b, expected valid=%0b sig=%h up=%0b inx=%0b",
               expTag, outValid, sigOut, roundedUp, inexact, expValid, expSig, expUp, expInx);
    end
  endtask

  // behavioural reference for one operand
  task automatic modelVec(input logic v, input logic [SIG_W-1:0] s, input logic st,
                          input logic sg, input logic [1:0] md, input string tag);
    bit lost, up;
    longint unsigned shifted;
    lost = (s[1] || s[0] || st);
    case (md)
      2'b01:   up = 1'b0;
      2'b10:   up = lost && !sg;
      2'b11:   up = lost && sg;
      default: up = s[1] && (s[0] || st || s[2]);
    endcase
    expValid = v;
    expTag = tag;
    if (v) begin
      shifted = longint'(s) / 4 + (up ? 1 : 0);
      expSig = shifted[SIG_W-2:0];
      expUp  = up;
      expInx = lost;
    end
  endtask

  task automatic applyVec(input logic v, input logic [SIG_W-1:0] s, input logic st,
                          input logic sg, input logic [1:0] md, input string tag);
    @(negedge clk);
    compareNow();
    inValid = v; sigIn = s; stickyIn = st; signIn = sg; modeIn = md;
    modelVec(v, s, st, sg, md, tag);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expTag = "R8";
    compareNow();                       // R8 reset state all zero
    rstN = 1'b1;
    // R2 exact in each mode
    applyVec(1, 32'h1234_5678, 0, 0, 2'b00, "R2");
    applyVec(1, 32'h8765_4320, 0, 1, 2'b10, "R2");
    applyVec(1, 32'hFFFF_FFFC, 0, 1, 2'b11, "R2");
    // R3 sticky only, nearest: inexact but no bump
    applyVec(1, 32'h0000_1000, 1, 0, 2'b00, "R3");
    applyVec(1, 32'h0000_1001, 0, 0, 2'b01, "R3");
    // R4 nearest: above half, ties even/odd, below half
    applyVec(1, 32'h0000_0013, 0, 0, 2'b00, "R4");
    applyVec(1, 32'h0000_0012, 0, 0, 2'b00, "R4");
    applyVec(1, 32'h0000_0016, 0, 0, 2'b00, "R4");
    applyVec(1, 32'h0000_0012, 1, 0, 2'b00, "R4");
    applyVec(1, 32'h0000_0015, 1, 1, 2'b00, "R4");
    // R5 toward zero
    applyVec(1, 32'h0000_00FF, 1, 0, 2'b01, "R5");
    applyVec(1, 32'h0000_00FF, 1, 1, 2'b01, "R5");
    // R6 directed infinities, both signs
    applyVec(1, 32'h0000_0101, 0, 0, 2'b10, "R6");
    applyVec(1, 32'h0000_0101, 0, 1, 2'b10, "R6");
    applyVec(1, 32'h0000_0100, 1, 1, 2'b11, "R6");
    applyVec(1, 32'h0000_0100, 1, 0, 2'b11, "R6");
    // R7 full carry into integer position
    applyVec(1, 32'hFFFF_FFFF, 0, 0, 2'b00, "R7");
    applyVec(1, 32'hFFFF_FFFD, 0, 0, 2'b10, "R7");
    applyVec(1, 32'hFFFF_FFFC, 1, 1, 2'b11, "R7");
    applyVec(1, 32'hFFFF_FFFF, 1, 0, 2'b11, "R7");
    applyVec(1, 32'hFFFF_FFFF, 1, 1, 2'b01, "R7");
    // R8 idle cycles hold previous outputs despite changing inputs
    applyVec(1, 32'h0000_0007, 0, 0, 2'b00, "R8");
    applyVec(0, 32'hFFFF_FFFF, 1, 1, 2'b11, "R8");
    applyVec(0, 32'h0000_0002, 0, 0, 2'b00, "R8");
    // R1 pseudo-random sweep
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      applyVec(1, lfsr, lfsr[7] ^ lfsr[13], lfsr[19], lfsr[25:24], "R1");
    end
    applyVec(0, 32'h0, 0, 0, 2'b00, "R1");
    @(negedge clk);
    compareNow();
    finishRun();
  end
endmodule